// File: doc/BRIEF.md
# I2C Slave Register-Access Interface

This block lets an external I2C master read and write a small bank of 8-bit configuration registers. It samples the SCL and SDA lines on the system clock and detects start, repeated start and stop conditions. It answers to one 7-bit slave address, picked from two fixed values by a strap input. The block has no open-drain pad of its own. It gives out one enable that, when high, pulls the SDA line low. The line is read back through `sda_i`.

A write transfer carries an address byte, a command byte and then any number of data bytes. The low six bits of the command byte load the register pointer. Each data byte goes to the register at the pointer, and the pointer then moves on by one. A read transfer returns the register at the current pointer. The pointer steps forward after every byte that the master acknowledges, so a command-only write followed by a repeated start and a read gives random read access. Clock stretching is not supported, and the block never holds SCL low.

Top module: `i2c_reg_slave`

## Requirements
- R1: The slave address is 7'h48 when `addr_sel` is 0 and 7'h49 when it is 1. On a match the slave pulls SDA low during the ninth SCL clock of the address byte.
- R2: The slave does not acknowledge any other address, including the general call (7'h00) and the 10-bit prefix 7'b11110xx. It then leaves SDA released, and no register or pointer changes before the next start.
- R3: In a write transfer (R/W bit 0), the slave acknowledges the command byte, and the command's bits [5:0] load the register pointer. Each following data byte is acknowledged and stored in the register at the pointer.
- R4: After each data byte of a write, the pointer advances by one, so that consecutive bytes reach consecutive registers.
- R5: A command byte whose bits [7:6] are not 2'b00 is still acknowledged, and so are its data bytes. The pointer loads and steps as usual, but no register is written.
- R6: In a read transfer (R/W bit 1), the slave sends the register at the pointer MSB first. It changes SDA only while SCL is low.
- R7: When the master acknowledges a read byte, the pointer advances by one and the next register is sent. When the master does not acknowledge, the pointer keeps its value and SDA stays released until the next start.
- R8: A pointer at or beyond NREGS reads as 8'h00. Writes there have no effect, though the byte is still acknowledged.
- R9: A repeated start at any byte boundary restarts address decoding without a stop.
- R10: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop returns the slave to idle with SDA released. Both lines pass through two synchronising flip-flops, and the block works with an SCL period of 12 system clocks or more.
- R11: After reset, every register holds 8'h00, the pointer is 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run at least 12 times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 1 | Strap that selects the slave address (0: 7'h48, 1: 7'h49) |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad (wired bus value) |
| sda_oe | output | 1 | Registered; 1 pulls SDA low, 0 releases it |

## Verification
Some properties are checked on every cycle:
- The SDA drive only switches on while the synchronised SCL is low.
- An idle slave never drives SDA.
- Any start puts the decoder back at bit zero of an address byte, and any stop brings it to idle.
- Every register write lands inside the bank and is followed by a single pointer step.

Other behaviour can only be shown by the bench's transfers:
- The values read back after bursts that run past the bank end.
- Commands with a bad top field.
- Ignored general-call and 10-bit addresses.
- Repeated starts in the middle of a write.

The bench compares these read-back values with its own model of the registers and the pointer.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  // Decoder phases of the serial engine
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_RDATA
  } i2cs_state_e;

  localparam int BYTE_W = 8;
  // Width of the register field carried in the command byte
  localparam int PTR_W = 6;
  // Bit counter spans 0..9 (eight data bits plus the acknowledge slot)
  localparam int BCNT_W = 4;
  localparam logic [BCNT_W-1:0] ACK_SLOT = 4'd8;
  localparam logic [BCNT_W-1:0] ACK_DONE = 4'd9;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic q,
  output logic q_prev
);
  // STAGES flops for metastability, one more for edge detection
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-1:0], din};
  end

  assign q      = chain_q[STAGES-1];
  assign q_prev = chain_q[STAGES];
endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank
  import i2cs_pkg::*;
#(
  parameter int NREGS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [BYTE_W-1:0] rdata
);
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [PTR_W:0] LIMIT = (PTR_W+1)'(NREGS);

  logic [BYTE_W-1:0] regs_q [NREGS];
  logic              w_ok;
  logic              r_ok;

  assign w_ok = ({1'b0, waddr} < LIMIT);
  assign r_ok = ({1'b0, raddr} < LIMIT);

  // Flop-based bank: needs a reset value and a same-cycle read
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (we && w_ok) begin
      regs_q[waddr[IDX_W-1:0]] <= wdata;
    end
  end

  assign rdata = r_ok ? regs_q[raddr[IDX_W-1:0]] : '0;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int          NREGS    = 16,
  parameter logic [6:0]  DEV_ADDR = 7'h48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_sel,
  input  logic              scl_s,
  input  logic              scl_d,
  input  logic              sda_s,
  input  logic              sda_d,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe,
  output i2cs_state_e       state_o,
  output logic [BCNT_W-1:0] bitcnt_o,
  output logic [PTR_W-1:0]  ptr_o
);
  localparam logic [PTR_W:0] LIMIT = (PTR_W+1)'(NREGS);

  i2cs_state_e       state_q;
  logic [BCNT_W-1:0] bitcnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] tx_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              rw_q;
  logic              cmd_ok_q;

  logic [6:0] my_addr;
  logic       start_ev;
  logic       stop_ev;
  logic       scl_rise;
  logic       scl_fall;

  assign my_addr  = {DEV_ADDR[6:1], DEV_ADDR[0] ^ addr_sel};
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;

  // A read looks one register ahead once it is streaming
  assign rd_ptr  = (state_q == ST_RDATA) ? ptr_q + 1'b1 : ptr_q;
  assign wr_ptr  = ptr_q;
  assign wr_data = shreg_q;
  assign wr_en   = (state_q == ST_WDATA) && scl_fall && (bitcnt_q == ACK_SLOT)
                   && cmd_ok_q && ({1'b0, ptr_q} < LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      rw_q     <= 1'b0;
      cmd_ok_q <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_ev) begin
      state_q  <= ST_ADDR;
      bitcnt_q <= '0;
      sda_oe   <= 1'b0;
    end else if (stop_ev) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      sda_oe   <= 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (scl_rise) begin
        shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
        if (bitcnt_q != ACK_DONE) bitcnt_q <= bitcnt_q + 1'b1;
      end else if (scl_fall) begin
        if (bitcnt_q == ACK_SLOT) begin
          // Eight bits have passed: decide the acknowledge slot
          case (state_q)
            ST_ADDR: begin
              if (shreg_q[7:1] == my_addr) begin
                rw_q   <= shreg_q[0];
                sda_oe <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end
            ST_CMD: begin
              ptr_q    <= shreg_q[PTR_W-1:0];
              cmd_ok_q <= (shreg_q[7:6] == 2'b00);
              sda_oe   <= 1'b1;
            end
            ST_WDATA: begin
              ptr_q  <= ptr_q + 1'b1;
              sda_oe <= 1'b1;
            end
            ST_RDATA: sda_oe <= 1'b0;
            default: ;
          endcase
        end else if (bitcnt_q == ACK_DONE) begin
          bitcnt_q <= '0;
          sda_oe   <= 1'b0;
          case (state_q)
            ST_ADDR: begin
              if (rw_q) begin
                state_q <= ST_RDATA;
                tx_q    <= rd_data;
                sda_oe  <= ~rd_data[7];
              end else begin
                state_q <= ST_CMD;
              end
            end
            ST_CMD: state_q <= ST_WDATA;
            ST_RDATA: begin
              if (!shreg_q[0]) begin
                ptr_q  <= ptr_q + 1'b1;
                tx_q   <= rd_data;
                sda_oe <= ~rd_data[7];
              end else begin
                state_q <= ST_IDLE;
              end
            end
            default: ;
          endcase
        end else if (state_q == ST_RDATA && bitcnt_q != '0) begin
          sda_oe <= ~tx_q[6];
          tx_q   <= {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  assign state_o  = state_q;
  assign bitcnt_o = bitcnt_q;
  assign ptr_o    = ptr_q;
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2cs_pkg::*;
#(
  parameter int         NREGS       = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h48
) (
  input  logic clk,
  input  logic rst,
  input  logic addr_sel,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw;
  logic [NLINES-1:0] line_s;
  logic [NLINES-1:0] line_d;
  logic scl_s, scl_d, sda_s, sda_d;

  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .din    (line_raw[g]),
      .q      (line_s[g]),
      .q_prev (line_d[g])
    );
  end

  assign scl_s = line_s[1];
  assign scl_d = line_d[1];
  assign sda_s = line_s[0];
  assign sda_d = line_d[0];

  logic [BYTE_W-1:0] rd_data;
  logic [PTR_W-1:0]  rd_ptr;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_ptr;
  logic [BYTE_W-1:0] wr_data;
  i2cs_state_e       eng_state;
  logic [BCNT_W-1:0] eng_bitcnt;
  logic [PTR_W-1:0]  eng_ptr;

  i2cs_engine #(.NREGS(NREGS), .DEV_ADDR(DEV_ADDR)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .addr_sel (addr_sel),
    .scl_s    (scl_s),
    .scl_d    (scl_d),
    .sda_s    (sda_s),
    .sda_d    (sda_d),
    .rd_data  (rd_data),
    .rd_ptr   (rd_ptr),
    .wr_en    (wr_en),
    .wr_ptr   (wr_ptr),
    .wr_data  (wr_data),
    .sda_oe   (sda_oe),
    .state_o  (eng_state),
    .bitcnt_o (eng_bitcnt),
    .ptr_o    (eng_ptr)
  );

  i2cs_regbank #(.NREGS(NREGS)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr (wr_ptr),
    .wdata (wr_data),
    .raddr (rd_ptr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk
  import i2cs_pkg::*;
#(
  parameter int NREGS = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_oe,
  input logic              scl_s,
  input logic              scl_d,
  input logic              sda_s,
  input logic              sda_d,
  input i2cs_state_e       state,
  input logic [BCNT_W-1:0] bitcnt,
  input logic [PTR_W-1:0]  ptr,
  input logic              wr_en
);
  localparam logic [PTR_W:0] LIMIT = (PTR_W+1)'(NREGS);

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);  // R6

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);  // R2

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (scl_s && scl_d && sda_d && !sda_s) |=> (state == ST_ADDR && bitcnt == '0 && !sda_oe));  // R9

  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (rst)
    (scl_s && scl_d && !sda_d && sda_s) |=> (state == ST_IDLE && !sda_oe));  // R10

  AST_WR_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ptr == PTR_W'($past(ptr) + 1'b1)));  // R4

  AST_WR_IN_BANK: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (({1'b0, ptr} < LIMIT) && state == ST_WDATA));  // R8
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.NREGS(NREGS)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .sda_oe (sda_oe),
  .scl_s  (scl_s),
  .scl_d  (scl_d),
  .sda_s  (sda_s),
  .sda_d  (sda_d),
  .state  (eng_state),
  .bitcnt (eng_bitcnt),
  .ptr    (eng_ptr),
  .wr_en  (wr_en)
);

// File: tb/i2c_reg_slave_test.sv
module i2c_reg_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREGS      = 16;
  localparam int IDX_W      = $clog2(NREGS);
  localparam int Q          = 3;  // quarter SCL period: 12 system clocks per bit (R10)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_sel = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic bus_sda;

  assign bus_sda = m_sda & ~sda_oe;

  i2c_reg_slave #(.NREGS(NREGS)) uut (
    .clk      (clk),
    .rst      (rst),
    .addr_sel (addr_sel),
    .scl_i    (m_scl),
    .sda_i    (bus_sda),
    .sda_oe   (sda_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [7:0] model [NREGS];
  logic [5:0] mptr = '0;

  task automatic check8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] dev();
    return addr_sel ? 7'h49 : 7'h48;
  endfunction

  function automatic logic [7:0] exp_rd();
    if (32'(mptr) < NREGS) return model[mptr[IDX_W-1:0]];
    return 8'h00;
  endfunction

  function automatic logic [7:0] rand_cmd();
    logic [5:0] p;
    logic [1:0] top;
    p = 6'($urandom_range(0, NREGS + 3));
    top = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
    return {top, p};
  endfunction

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; hold();
    m_scl = 1'b1; hold();
    m_sda = 1'b0; hold();
    m_scl = 1'b0; hold();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; hold();
    m_scl = 1'b1; hold();
    m_sda = 1'b1; hold();
  endtask

  task automatic wbit(input logic b);
    m_sda = b; hold();
    m_scl = 1'b1; hold();
    hold();
    m_scl = 1'b0; hold();
  endtask

  task automatic rbit(output logic b);
    m_sda = 1'b1; hold();
    m_scl = 1'b1; hold();
    b = bus_sda; hold();
    m_scl = 1'b0; hold();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
    wbit(~give_ack);
  endtask

  // Write transfer: address, command, n random data bytes
  task automatic wr_burst(input logic [7:0] cmd, input int n, input bit do_stop);
    logic ack;
    logic ok;
    logic [7:0] d;
    i2c_start();
    wbyte({dev(), 1'b0}, ack);
    check8("R1", "write address ack", 8'(ack), 8'h01);
    wbyte(cmd, ack);
    check8("R3", "command ack", 8'(ack), 8'h01);
    mptr = cmd[5:0];
    ok = (cmd[7:6] == 2'b00);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      wbyte(d, ack);
      if (!ok) check8("R5", "data ack after bad command", 8'(ack), 8'h01);
      else if (32'(mptr) >= NREGS) check8("R8", "data ack past bank end", 8'(ack), 8'h01);
      else check8("R3", "data ack", 8'(ack), 8'h01);
      if (ok && 32'(mptr) < NREGS) model[mptr[IDX_W-1:0]] = d;
      mptr = mptr + 1'b1;  // R4
    end
    if (do_stop) i2c_stop();
  endtask

  // Read transfer of n bytes, last one not acknowledged
  task automatic rd_burst(input int n, input string tag);
    logic ack;
    logic [7:0] d;
    i2c_start();
    wbyte({dev(), 1'b1}, ack);
    check8("R1", "read address ack", 8'(ack), 8'h01);
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, d);
      if (32'(mptr) >= NREGS) check8("R8", "read past bank end", d, 8'h00);
      else check8(tag, "read data", d, exp_rd());
      if (i != n - 1) mptr = mptr + 1'b1;  // R7
    end
    check8("R7", "SDA released after NACK", 8'(sda_oe), 8'h00);
    i2c_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: run did not complete actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [31:0] seed_init;
    seed_init = $urandom(32'd20240611);
    for (int i = 0; i < NREGS; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R11: reset state
    check8("R11", "sda_oe after reset", 8'(sda_oe), 8'h00);
    rd_burst(1, "R11");  // pointer 0 after reset
    wr_burst(8'h00, 0, 1'b0);
    rd_burst(NREGS, "R11");

    // R3/R4: multi-byte write, read back across the burst
    wr_burst(8'h04, 4, 1'b1);
    wr_burst(8'h04, 0, 1'b0);
    rd_burst(4, "R4");

    // R2: general call ignored, data after it has no effect
    i2c_start();
    wbyte(8'h00, ack);
    check8("R2", "general call ack", 8'(ack), 8'h00);
    wbyte(8'h04, ack);
    wbyte(8'hA5, ack);
    i2c_stop();
    wr_burst(8'h04, 0, 1'b0);
    rd_burst(2, "R2");

    // R2: 10-bit address prefix never acknowledged
    i2c_start();
    wbyte(8'hF0, ack);
    check8("R2", "10-bit prefix ack", 8'(ack), 8'h00);
    i2c_stop();

    // R1: the other select value is not answered
    addr_sel = 1'b0;
    i2c_start();
    wbyte({7'h49, 1'b0}, ack);
    check8("R1", "0x49 with select 0", 8'(ack), 8'h00);
    i2c_stop();
    addr_sel = 1'b1;
    i2c_start();
    wbyte({7'h48, 1'b0}, ack);
    check8("R1", "0x48 with select 1", 8'(ack), 8'h00);
    i2c_stop();
    wr_burst(8'h01, 2, 1'b1);

    // R5: command with nonzero top bits discards data
    wr_burst(8'h83, 2, 1'b1);
    wr_burst(8'h03, 0, 1'b0);
    rd_burst(2, "R5");

    // R8: writes and reads running past the last register
    wr_burst(8'(NREGS - 1), 3, 1'b1);
    wr_burst(8'(NREGS - 1), 0, 1'b0);
    rd_burst(3, "R8");

    // R9: repeated start in the middle of a write, foreign address
    wr_burst(8'h02, 1, 1'b0);
    i2c_start();
    wbyte({dev() ^ 7'h01, 1'b0}, ack);
    check8("R9", "foreign address after repeated start", 8'(ack), 8'h00);
    i2c_stop();
    wr_burst(8'h02, 0, 1'b0);
    rd_burst(1, "R9");

    // R10: stop right after the address returns to idle
    i2c_start();
    wbyte({dev(), 1'b0}, ack);
    check8("R10", "address ack before early stop", 8'(ack), 8'h01);
    i2c_stop();
    check8("R10", "sda_oe after stop", 8'(sda_oe), 8'h00);
    rd_burst(1, "R10");

    // Random traffic
    for (int it = 0; it < 48; it++) begin
      int kind;
      addr_sel = 1'($urandom_range(0, 1));
      kind = $urandom_range(0, 2);
      case (kind)
        0: wr_burst(rand_cmd(), $urandom_range(1, 4), 1'b1);
        1: rd_burst($urandom_range(1, 4), "R6");
        default: begin
          wr_burst(rand_cmd(), 0, 1'b0);
          rd_burst($urandom_range(1, 3), "R9");
        end
      endcase
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule